// File: doc/BRIEF.md
# Priority-Ordered Transmit Queue with Tail Eviction

This block holds a small number of outgoing messages between a host and a shared transmit medium. Each message is a tag paired with a priority, where a larger priority value means more urgent. Entries are kept sorted so that the most urgent message is always at the head, where the transmitter can see it and pop it.

A full queue does not stall urgent traffic. A host push that is more urgent than the least urgent stored entry overwrites that tail entry. The tag of the displaced entry is reported on the cycle after the overwrite, so the host, which keeps a copy of every message until it has been sent, can resubmit it later. A push that is not more urgent than the tail of a full queue is refused with a same-cycle busy indication and leaves the queue unchanged. Pops and pushes may occur in the same cycle. The pop is always applied first.

Top module: `txq_prio_queue`

## Requirements
- R1: After reset the queue is empty: count is 0, empty is 1, full is 0 and evict_valid is 0.
- R2: While count is nonzero, head_valid is 1 and head_prio/head_tag show the stored entry with the largest priority value. Stored priorities never increase from head toward tail.
- R3: Entries of equal priority leave in arrival order. A new entry goes behind every stored entry whose priority is greater than or equal to its own.
- R4: A push to a queue that is not full (after any same-cycle pop) is stored, and count rises by one on the next cycle.
- R5: A pop while the queue is nonempty removes the head, and count falls by one on the next cycle. A pop on an empty queue has no effect.
- R6: A push to a full queue without a pop, with priority strictly greater than the tail priority, replaces the tail entry and leaves count at its maximum. In the following cycle evict_valid is 1 for exactly one cycle and evict_tag holds the displaced tag.
- R7: A push to a full queue without a pop, with priority less than or equal to the tail priority, raises push_busy in the same cycle and leaves count and contents unchanged.
- R8: A push and a pop in the same cycle on a full queue remove the head first and then insert the new entry without eviction, whatever its priority. Count stays at its maximum and evict_valid stays 0.
- R9: full is 1 exactly when count equals the depth, empty is 1 exactly when count is 0, and count never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_valid | input | 1 | Host offers a message this cycle |
| push_prio | input | 8 | Priority of the offered message (larger is more urgent) |
| push_tag | input | 16 | Identifier of the offered message |
| push_busy | output | 1 | Offer refused this cycle (full, no pop, not more urgent than tail) |
| pop | input | 1 | Transmitter takes the head entry |
| head_valid | output | 1 | Head entry present |
| head_prio | output | 8 | Priority of the head entry |
| head_tag | output | 16 | Tag of the head entry |
| evict_valid | output | 1 | One-cycle pulse: a tail entry was displaced in the previous cycle |
| evict_tag | output | 16 | Tag of the displaced entry |
| count | output | 3 | Number of stored entries |
| full | output | 1 | Queue holds the maximum number of entries |
| empty | output | 1 | Queue holds no entries |

## Verification
On every cycle, the assertions check the priority order of the live entries, the count bound, that a refused push leaves count and head untouched, that an eviction pulse follows only a full queue that stayed full, and that a pop on an empty queue with no push keeps the queue empty. Arrival order among equal priorities, the exact tag that is evicted, and the pop-before-push rule on a full queue can only be shown by the bench. It compares every head, count, busy and eviction result against an arithmetic model over a long pseudo-random run with few distinct priorities, and adds directed tie and full-queue sequences.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    TXQ_IDLE   = 2'd0,
    TXQ_INSERT = 2'd1,
    TXQ_EVICT  = 2'd2,
    TXQ_REFUSE = 2'd3
  } txq_op_e;
endpackage

// File: rtl/txq_rank.sv
// Finds where a new entry goes: after every live entry with priority >= new.
module txq_rank #(
  parameter int DEPTH = 4,
  parameter int PW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [PW-1:0] slot_prio [DEPTH],
  input  logic [CW-1:0] live,
  input  logic [PW-1:0] new_prio,
  output logic [CW-1:0] pos
);
  logic [DEPTH-1:0] ahead;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign ahead[i] = (CW'(i) < live) && (slot_prio[i] >= new_prio);
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = pos + CW'(ahead[i]);
    end
  end
endmodule

// File: rtl/txq_slot.sv
// Next value of one queue slot given the post-pop array and an insert.
module txq_slot #(
  parameter int PW  = 8,
  parameter int TW  = 16,
  parameter int CW  = 3,
  parameter int IDX = 0
) (
  input  logic [PW-1:0] self_prio,
  input  logic [TW-1:0] self_tag,
  input  logic [PW-1:0] upper_prio,
  input  logic [TW-1:0] upper_tag,
  input  logic          ins_do,
  input  logic [CW-1:0] ins_pos,
  input  logic [PW-1:0] new_prio,
  input  logic [TW-1:0] new_tag,
  output logic [PW-1:0] nxt_prio,
  output logic [TW-1:0] nxt_tag
);
  localparam logic [CW-1:0] MY_IDX = CW'(IDX);

  always_comb begin
    nxt_prio = self_prio;
    nxt_tag  = self_tag;
    if (ins_do) begin
      if (MY_IDX == ins_pos) begin
        nxt_prio = new_prio;
        nxt_tag  = new_tag;
      end else if (MY_IDX > ins_pos) begin
        nxt_prio = upper_prio;
        nxt_tag  = upper_tag;
      end
    end
  end
endmodule

// File: rtl/txq_prio_queue.sv
module txq_prio_queue #(
  parameter int DEPTH = 4,
  parameter int PW    = 8,
  parameter int TW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [PW-1:0] push_prio,
  input  logic [TW-1:0] push_tag,
  output logic          push_busy,
  input  logic          pop,
  output logic          head_valid,
  output logic [PW-1:0] head_prio,
  output logic [TW-1:0] head_tag,
  output logic          evict_valid,
  output logic [TW-1:0] evict_tag,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  import txq_pkg::*;

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // storage
  logic [PW-1:0] q_prio [DEPTH];
  logic [TW-1:0] q_tag  [DEPTH];
  logic [CW-1:0] cnt_q;

  // next-state signals
  logic          pop_do;
  logic [CW-1:0] cnt_pop;
  logic          room;
  logic          beats_tail;
  txq_op_e       op;
  logic          ins_do;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] ins_pos;
  logic          store_en;
  logic [PW-1:0] s_prio [DEPTH];
  logic [TW-1:0] s_tag  [DEPTH];
  logic [PW-1:0] d_prio [DEPTH];
  logic [TW-1:0] d_tag  [DEPTH];

  always_comb begin
    pop_do     = pop && (cnt_q != '0);
    cnt_pop    = cnt_q - CW'(pop_do);
    room       = cnt_pop < CAP;
    beats_tail = push_prio > q_prio[DEPTH-1];
    if (!push_valid)     op = TXQ_IDLE;
    else if (room)       op = TXQ_INSERT;
    else if (beats_tail) op = TXQ_EVICT;
    else                 op = TXQ_REFUSE;
    ins_do   = (op == TXQ_INSERT) || (op == TXQ_EVICT);
    cnt_d    = (op == TXQ_INSERT) ? cnt_pop + CW'(1) : cnt_pop;
    store_en = pop_do || ins_do;
  end

  // array after the pop, pop is applied before insertion
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i == DEPTH - 1) begin : g_last
      assign s_prio[i] = pop_do ? '0 : q_prio[i];
      assign s_tag[i]  = pop_do ? '0 : q_tag[i];
    end else begin : g_mid
      assign s_prio[i] = pop_do ? q_prio[i+1] : q_prio[i];
      assign s_tag[i]  = pop_do ? q_tag[i+1]  : q_tag[i];
    end
  end

  txq_rank #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_rank (
    .slot_prio (s_prio),
    .live      (cnt_pop),
    .new_prio  (push_prio),
    .pos       (ins_pos)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PW-1:0] up_prio;
    logic [TW-1:0] up_tag;
    if (i == 0) begin : g_top
      assign up_prio = '0;
      assign up_tag  = '0;
    end else begin : g_rest
      assign up_prio = s_prio[i-1];
      assign up_tag  = s_tag[i-1];
    end
    txq_slot #(.PW(PW), .TW(TW), .CW(CW), .IDX(i)) u_slot (
      .self_prio  (s_prio[i]),
      .self_tag   (s_tag[i]),
      .upper_prio (up_prio),
      .upper_tag  (up_tag),
      .ins_do     (ins_do),
      .ins_pos    (ins_pos),
      .new_prio   (push_prio),
      .new_tag    (push_tag),
      .nxt_prio   (d_prio[i]),
      .nxt_tag    (d_tag[i])
    );
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (store_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        q_prio[i] <= d_prio[i];
        q_tag[i]  <= d_tag[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) evict_valid <= 1'b0;
    else        evict_valid <= (op == TXQ_EVICT);
  end

  always_ff @(posedge clk) begin
    if (op == TXQ_EVICT) evict_tag <= q_tag[DEPTH-1];
  end

  // outputs
  assign push_busy  = (op == TXQ_REFUSE);
  assign head_valid = (cnt_q != '0);
  assign head_prio  = q_prio[0];
  assign head_tag   = q_tag[0];
  assign count      = cnt_q;
  assign full       = (cnt_q == CAP);
  assign empty      = (cnt_q == '0);

  // checks
  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_order_chk
    // R2
    sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (cnt_q > CW'(i + 1)) |-> (q_prio[i] >= q_prio[i+1]));
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q <= CAP);

  // R7
  refuse_stable_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (push_valid && push_busy) |=> ($stable(cnt_q) && $stable(head_tag)));

  // R6
  evict_when_full_chk: assert property (@(posedge clk) disable iff (!rst_q)
    evict_valid |-> (full && $past(full)));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (empty && pop && !push_valid) |=> empty);

  // R4
  insert_grow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (push_valid && !pop && !full) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: tb/test_txq_prio_queue.sv
module test_txq_prio_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk;
  logic        rst_n;
  logic        push_valid;
  logic [7:0]  push_prio;
  logic [15:0] push_tag;
  logic        push_busy;
  logic        pop;
  logic        head_valid;
  logic [7:0]  head_prio;
  logic [15:0] head_tag;
  logic        evict_valid;
  logic [15:0] evict_tag;
  logic [2:0]  count;
  logic        full;
  logic        empty;

  txq_prio_queue i_txq_prio_queue (
    .clk, .rst_n, .push_valid, .push_prio, .push_tag, .push_busy, .pop,
    .head_valid, .head_prio, .head_tag, .evict_valid, .evict_tag,
    .count, .full, .empty
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  logic [7:0]  mp [DEPTH];
  logic [15:0] mt [DEPTH];
  int          mc = 0;
  logic [15:0] next_tag = 16'h0100;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; inputs driven at negedge, results sampled at next negedge
  task automatic step(input bit pu, input logic [7:0] pr, input bit po, input string lbl);
    bit          eb, ee;
    logic [15:0] etag;
    int          pos;
    push_valid = pu;
    push_prio  = pr;
    push_tag   = next_tag;
    pop        = po;
    #1;
    eb = pu && (mc == DEPTH) && !po && (pr <= mp[DEPTH-1]);
    ee = pu && (mc == DEPTH) && !po && (pr >  mp[DEPTH-1]);
    etag = mt[DEPTH-1];
    chk(push_busy == eb, (lbl != "") ? lbl : "R7", int'(push_busy), int'(eb));
    if (po && mc > 0) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        mp[i] = mp[i+1];
        mt[i] = mt[i+1];
      end
      mc--;
    end
    if (pu && !eb) begin
      if (mc == DEPTH) mc--;
      pos = 0;
      while (pos < mc && mp[pos] >= pr) pos++;
      for (int i = DEPTH - 1; i > pos; i--) begin
        mp[i] = mp[i-1];
        mt[i] = mt[i-1];
      end
      mp[pos] = pr;
      mt[pos] = next_tag;
      mc++;
    end
    next_tag++;
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    pop = 1'b0;
    chk(int'(count) == mc, (lbl != "") ? lbl : "R4/R5 count", int'(count), mc);
    chk(full == (mc == DEPTH) && empty == (mc == 0), "R9 flags", int'({full, empty}),
        int'({mc == DEPTH, mc == 0}));
    chk(head_valid == (mc > 0), "R2 head_valid", int'(head_valid), int'(mc > 0));
    if (mc > 0) begin
      chk(head_tag == mt[0], (lbl != "") ? lbl : "R2 head_tag", int'(head_tag), int'(mt[0]));
      chk(head_prio == mp[0], "R2 head_prio", int'(head_prio), int'(mp[0]));
    end
    chk(evict_valid == ee, (lbl != "") ? lbl : "R6 evict_valid", int'(evict_valid), int'(ee));
    if (ee) chk(evict_tag == etag, "R6 evict_tag", int'(evict_tag), int'(etag));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    logic [15:0] first_tag;
    push_valid = 1'b0;
    push_prio  = '0;
    push_tag   = '0;
    pop        = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      mp[i] = '0;
      mt[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(count == 3'd0, "R1 count", int'(count), 0);
    chk(empty && !full, "R1 flags", int'({full, empty}), 1);
    chk(!evict_valid, "R1 evict_valid", int'(evict_valid), 0);

    // R5 pop on empty
    step(1'b0, 8'd0, 1'b1, "R5");

    // R3 equal priorities keep arrival order
    first_tag = next_tag;
    step(1'b1, 8'd50, 1'b0, "R3");
    step(1'b1, 8'd50, 1'b0, "R3");
    step(1'b1, 8'd50, 1'b0, "R3");
    chk(head_tag == first_tag, "R3 oldest at head", int'(head_tag), int'(first_tag));
    step(1'b1, 8'd80, 1'b0, "R2");
    step(1'b1, 8'd50, 1'b0, "R7");   // full, equal to tail: refused
    step(1'b1, 8'd10, 1'b0, "R7");   // full, below tail: refused
    step(1'b0, 8'd0, 1'b1, "R3");
    chk(head_tag == first_tag, "R3 order after pop", int'(head_tag), int'(first_tag));
    step(1'b1, 8'd50, 1'b0, "R3");   // full again, newest 50 at tail
    step(1'b1, 8'd51, 1'b0, "R6");   // evicts newest 50
    step(1'b1, 8'd200, 1'b1, "R8");  // full, push+pop: no eviction
    step(1'b1, 8'd0, 1'b1, "R8");    // full, lowest prio still inserted
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 8'd0, 1'b1, "R5");

    // long pseudo-random sweep with few distinct priorities
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[2:0] < 3'd5, (lf[9:8] == 2'd3 && lf[10]) ? 8'd255 : 8'(lf[5:4]) * 8'd60,
           lf[7:6] == 2'd0 || (lf[3] && lf[11]), "");
    end

    finish_run();
  end
endmodule